// File: doc/BRIEF.md
# Two-Die Interleaved Page Read Sequencer

This controller sits on the host side of a NAND bus that two stacked dies share under a single chip enable. One host request starts a complete interleaved read. The sequencer waits until the shared ready/busy line shows both dies idle. It then sends a page-read command to the first die. It watches the line go low and, while the first die is still busy, sends the same read to the second die. The shared line only reports that both dies are ready, so it cannot tell which die has finished.

To learn when each die is done, the sequencer uses a status read that names a die by its row address. That read is command 78h followed by three row bytes, and the selected die returns one status byte. The sequencer repeats this poll until bit 6 of the status byte, the ready bit, is set. It then sends 00h, which puts only that die into data-output mode, and reads out the requested number of bytes. The first die is drained first, then the second. The plain status command 70h is never sent, because both dies would answer it at once.

Requests are rejected when the two dies are asked for different operations, or for an operation other than a plain page read. A die that stays not-ready for too many polls aborts the pass with an error.

Top module: `nand_ilv_rd_seq`

## Requirements
- R1: Each die's read is sent as command 00h, two column bytes of 00h, the three row bytes (low byte first), then command 30h. The first die (row 1) is read before the second die (row 2).
- R2: The first die's command starts only after ready/busy has been seen high. The second die's command starts only after ready/busy has been seen low following the first die's 30h.
- R3: Before data is read from a die, that die is polled with command 78h and its three row bytes, then one status read. The poll repeats until status bit 6 is 1, and is then followed by command 00h.
- R4: Command 70h is never emitted.
- R5: For each die, `req_len` data bytes are delivered on `rd_data` with one `rd_valid` pulse each, first die first. `done1` pulses once after the first die's bytes and `done2` once after the second die's. A length of 0 gives both done pulses with no data.
- R6: A request whose `req_op1` and `req_op2` differ is rejected. `err` pulses one cycle later with `err_code` 1, and there is no NAND bus activity.
- R7: Operation code 0 is a page read and is the only code accepted. Codes 1 (cache read), 2 (copyback read) and 3 are rejected with `err_code` 2 when both ops are equal.
- R8: If a die reports not-ready for `MAX_POLL` consecutive polls, the pass aborts. `err` pulses with `err_code` 3 and `busy` returns low without any done pulse.
- R9: Each command, address or data byte uses one strobe that is low for exactly one cycle. `nand_we_n` and `nand_re_n` are never low together, and `nand_io_oe` is low while `nand_re_n` is low.
- R10: After reset, `busy`, `nand_cle`, `nand_ale`, `nand_io_oe` and `err` are 0, and both strobes are 1.
- R11: A request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start pulse for an interleaved pass |
| req_op1 | input | 2 | Operation requested for die 1 (0 page, 1 cache, 2 copyback) |
| req_op2 | input | 2 | Operation requested for die 2 |
| req_row1 | input | 24 | Row address for die 1 |
| req_row2 | input | 24 | Row address for die 2 |
| req_len | input | CNT_W | Bytes to read from each die |
| busy | output | 1 | Pass in progress |
| done1 | output | 1 | Die 1 data complete (pulse) |
| done2 | output | 1 | Die 2 data complete, pass finished (pulse) |
| err | output | 1 | Request rejected or pass aborted (pulse) |
| err_code | output | 2 | 1 mixed ops, 2 unsupported op, 3 poll timeout |
| rd_valid | output | 1 | Data byte valid (pulse) |
| rd_data | output | 8 | Data byte read from the NAND |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the NAND bus |
| nand_io_oe | output | 1 | Host drives the NAND bus |
| nand_io_in | input | 8 | Byte read from the NAND bus |
| nand_rb | input | 1 | Shared ready/busy, high when both dies are ready |

## Verification
The assertion on the second die's command assumes that the shared ready/busy line, once low after the first die's confirm, stays low for at least two more cycles. The bench's two-die model therefore keeps each die busy for at least 30 cycles after its 30h. The model also keeps every busy period short enough that each die turns ready within the poll limit, except in the one test that deliberately exceeds it. The model's status and data replies depend only on the row address given in the latest 78h poll, so a read from the wrong die shows up as wrong data bytes.

// File: rtl/nand_ilv_rd_seq.sv
module nand_ilv_rd_seq #(
  parameter int CNT_W    = 12,
  parameter int MAX_POLL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op1,
  input  logic [1:0]       req_op2,
  input  logic [23:0]      req_row1,
  input  logic [23:0]      req_row2,
  input  logic [CNT_W-1:0] req_len,
  output logic             busy,
  output logic             done1,
  output logic             done2,
  output logic             err,
  output logic [1:0]       err_code,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb
);
  localparam int PW = $clog2(MAX_POLL + 1);
  localparam logic [1:0] OP_PAGE = 2'd0;

  typedef enum logic [2:0] {
    S_IDLE, S_WRDY, S_RD, S_WBSY, S_GAP, S_POLL, S_OUT, S_DATA
  } st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] idx, len_q;
  logic [PW-1:0]    pcnt;
  logic [23:0]      row1_q, row2_q;
  logic [7:0]       stat_q;
  logic             die, sub;
  logic             cle_c, ale_c, rd_c, last;
  logic [7:0]       byte_c;
  wire  [23:0]      row = die ? row2_q : row1_q;

  always_comb begin
    cle_c = 1'b0; ale_c = 1'b0; rd_c = 1'b0; byte_c = 8'h00; last = 1'b0;
    case (st)
      S_RD: begin
        last = (idx[2:0] == 3'd6);
        case (idx[2:0])
          3'd0:       cle_c = 1'b1;
          3'd1, 3'd2: ale_c = 1'b1;
          3'd3:       begin ale_c = 1'b1; byte_c = row[7:0];   end
          3'd4:       begin ale_c = 1'b1; byte_c = row[15:8];  end
          3'd5:       begin ale_c = 1'b1; byte_c = row[23:16]; end
          default:    begin cle_c = 1'b1; byte_c = 8'h30;      end
        endcase
      end
      S_POLL: begin
        last = (idx[2:0] == 3'd4);
        case (idx[2:0])
          3'd0:    begin cle_c = 1'b1; byte_c = 8'h78;      end
          3'd1:    begin ale_c = 1'b1; byte_c = row[7:0];   end
          3'd2:    begin ale_c = 1'b1; byte_c = row[15:8];  end
          3'd3:    begin ale_c = 1'b1; byte_c = row[23:16]; end
          default: rd_c = 1'b1;
        endcase
      end
      S_OUT:  begin cle_c = 1'b1; last = 1'b1; end
      S_DATA: begin rd_c = 1'b1; last = (idx == len_q - 1'b1); end
      default: ;
    endcase
  end

  assign busy        = (st != S_IDLE);
  assign nand_cle    = cle_c;
  assign nand_ale    = ale_c;
  assign nand_io_out = byte_c;
  assign nand_io_oe  = cle_c | ale_c;
  assign nand_we_n   = !((cle_c | ale_c) && !sub);
  assign nand_re_n   = !(rd_c && !sub);
  assign rd_data     = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; idx <= '0; len_q <= '0; pcnt <= '0;
      row1_q <= '0; row2_q <= '0; stat_q <= '0; die <= 1'b0; sub <= 1'b0;
      done1 <= 1'b0; done2 <= 1'b0; err <= 1'b0; err_code <= 2'd0; rd_valid <= 1'b0;
    end else begin
      done1 <= 1'b0; done2 <= 1'b0; err <= 1'b0; rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_op1 != req_op2) begin err <= 1'b1; err_code <= 2'd1; end
          else if (req_op1 != OP_PAGE) begin err <= 1'b1; err_code <= 2'd2; end
          else begin
            row1_q <= req_row1; row2_q <= req_row2; len_q <= req_len;
            die <= 1'b0; idx <= '0; sub <= 1'b0; st <= S_WRDY;
          end
        end
        S_WRDY: if (nand_rb) st <= S_RD;
        S_WBSY: if (!nand_rb) begin die <= 1'b1; st <= S_GAP; nxt <= S_RD; end
        S_GAP:  st <= nxt;
        default: begin
          if (!sub) begin
            sub <= 1'b1;
            if (rd_c) begin
              stat_q <= nand_io_in;
              rd_valid <= (st == S_DATA);
            end
          end else begin
            sub <= 1'b0;
            if (!last) idx <= idx + 1'b1;
            else begin
              idx <= '0;
              case (st)
                S_RD:
                  if (!die) st <= S_WBSY;
                  else begin die <= 1'b0; pcnt <= '0; st <= S_GAP; nxt <= S_POLL; end
                S_POLL:
                  if (stat_q[6]) begin st <= S_GAP; nxt <= S_OUT; end
                  else if (pcnt == PW'(MAX_POLL - 1)) begin
                    err <= 1'b1; err_code <= 2'd3; st <= S_IDLE;
                  end else begin pcnt <= pcnt + 1'b1; st <= S_GAP; nxt <= S_POLL; end
                default:
                  if (st == S_OUT && len_q != '0) begin st <= S_GAP; nxt <= S_DATA; end
                  else if (!die) begin
                    done1 <= 1'b1; die <= 1'b1; pcnt <= '0; st <= S_GAP; nxt <= S_POLL;
                  end else begin done2 <= 1'b1; st <= S_IDLE; end
              endcase
            end
          end
        end
      endcase
    end
  end

  p_no_plain_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && !nand_we_n && nand_io_out == 8'h70));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

  p_we_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |=> nand_we_n);

  p_die1_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && !die && idx == '0 && !sub) |-> $past(nand_rb));

  p_die2_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && die && idx == '0 && !sub) |-> !$past(nand_rb, 2));

  p_mixed_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op1 != req_op2) |=> (err && err_code == 2'd1 && !busy));

  p_done_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done1, done2, err}));
endmodule

// File: tb/test_nand_ilv_rd_seq.sv
module test_nand_ilv_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int MAXP  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op1 = 2'd0, req_op2 = 2'd0;
  logic [23:0] req_row1 = '0, req_row2 = '0;
  logic [CNT_W-1:0] req_len = '0;
  logic busy, done1, done2, err, rd_valid, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [1:0] err_code;
  logic [7:0] rd_data, nand_io_out, nand_io_in;
  logic nand_rb;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ilv_rd_seq #(.CNT_W(CNT_W), .MAX_POLL(MAXP)) i_nand_ilv_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op1(req_op1), .req_op2(req_op2),
    .req_row1(req_row1), .req_row2(req_row2), .req_len(req_len), .busy(busy),
    .done1(done1), .done2(done2), .err(err), .err_code(err_code), .rd_valid(rd_valid),
    .rd_data(rd_data), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb));

  int errors = 0, checks = 0;
  logic clr = 1'b0;

  // two-die model
  logic [15:0] bdur [2];
  logic [15:0] bcnt [2];
  logic [7:0]  ptr [2];
  logic [23:0] rowcap [2];
  logic [7:0]  abuf [6];
  logic [2:0]  acnt;
  logic [7:0]  lastc;
  logic [1:0]  mode;
  logic        sel;
  int n70, n30, nwe, ordbad, colbad, r2bad, cont, badrd, polls0, polls1;

  assign nand_rb = (bcnt[0] == 16'd0) && (bcnt[1] == 16'd0);
  wire [7:0] pat = (rowcap[sel][7:0] + ptr[sel]) ^ (sel ? 8'h5A : 8'h00);
  assign nand_io_in = nand_re_n ? 8'h00 :
                      (mode == 2'd1) ? {1'b0, bcnt[sel] == 16'd0, 6'b0} :
                      (mode == 2'd2) ? pat : 8'hFF;

  initial begin bcnt[0] = 0; bcnt[1] = 0; bdur[0] = 40; bdur[1] = 40; end

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) if (bcnt[d] != 0) bcnt[d] <= bcnt[d] - 1'b1;
    if (clr) begin
      n70 <= 0; n30 <= 0; nwe <= 0; ordbad <= 0; colbad <= 0; r2bad <= 0;
      cont <= 0; badrd <= 0; polls0 <= 0; polls1 <= 0; mode <= 2'd0; acnt <= 0; sel <= 1'b0;
    end else if (rst_n) begin
      if (!nand_we_n) begin
        nwe <= nwe + 1;
        if (nand_cle) begin
          lastc <= nand_io_out; acnt <= 0;
          if (nand_io_out == 8'h70) n70 <= n70 + 1;
          if (nand_io_out == 8'h00) begin
            mode <= (mode == 2'd1) ? 2'd2 : 2'd0;
            if (n30 == 0 && !nand_rb) r2bad <= r2bad + 1;
          end
          if (nand_io_out == 8'h30) begin
            bcnt[abuf[4][7]] <= bdur[abuf[4][7]];
            rowcap[abuf[4][7]] <= {abuf[4], abuf[3], abuf[2]};
            ptr[abuf[4][7]] <= 8'd0;
            if (abuf[0] != 0 || abuf[1] != 0) colbad <= colbad + 1;
            if (abuf[4][7] != (n30 != 0)) ordbad <= ordbad + 1;
            if (abuf[4][7] && nand_rb) r2bad <= r2bad + 1;
            n30 <= n30 + 1; mode <= 2'd0;
          end
        end else if (nand_ale) begin
          abuf[acnt] <= nand_io_out; acnt <= acnt + 1'b1;
          if (lastc == 8'h78 && acnt == 3'd2) begin
            sel <= nand_io_out[7]; mode <= 2'd1;
            if (nand_io_out[7]) polls1 <= polls1 + 1; else polls0 <= polls0 + 1;
          end
        end
      end
      if (!nand_re_n) begin
        if (nand_io_oe) cont <= cont + 1;
        if (mode == 2'd2) ptr[sel] <= ptr[sel] + 1'b1;
        if (mode == 2'd0) badrd <= badrd + 1;
      end
    end
  end

  // host-side monitor
  logic [23:0] e_row [2];
  int nbytes, nb_die, mism, d1n, d2n, errn, mis_act, mis_exp;
  logic cur;
  logic [1:0] lcode;
  always @(negedge clk) begin
    if (clr) begin
      nbytes <= 0; nb_die <= 0; mism <= 0; d1n <= 0; d2n <= 0; errn <= 0; cur <= 1'b0; lcode <= 2'd0;
    end else begin
      if (rd_valid) begin
        nbytes <= nbytes + 1; nb_die <= nb_die + 1;
        if (rd_data != ((e_row[cur][7:0] + 8'(nb_die)) ^ (cur ? 8'h5A : 8'h00))) begin
          mism <= mism + 1; mis_act <= int'(rd_data);
          mis_exp <= int'((e_row[cur][7:0] + 8'(nb_die)) ^ (cur ? 8'h5A : 8'h00));
        end
      end
      if (done1) begin d1n <= d1n + 1; cur <= 1'b1; nb_die <= 0; end
      if (done2) d2n <= d2n + 1;
      if (err) begin errn <= errn + 1; lcode <= err_code; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic start(input [1:0] o1, input [1:0] o2, input [23:0] r1, input [23:0] r2,
                       input [CNT_W-1:0] len);
    req_op1 = o1; req_op2 = o2; req_row1 = r1; req_row2 = r2; req_len = len;
    req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int t = 0; t < 20000 && d2n == 0 && errn == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_vec(input [23:0] r1, input [23:0] r2, input [CNT_W-1:0] len,
                         input [15:0] b1, input [15:0] b2, input bit inject);
    clear();
    bdur[0] = b1; bdur[1] = b2; e_row[0] = r1; e_row[1] = r2;
    start(2'd0, 2'd0, r1, r2, len);
    if (inject) begin
      repeat (8) @(negedge clk);
      start(2'd0, 2'd1, 24'h0, 24'h0, 0);
    end
    wait_end();
    chk(d1n == 1 && d2n == 1, "R5 done pulses", d1n * 10 + d2n, 11);
    chk(nbytes == 2 * int'(len), "R5 byte count", nbytes, 2 * int'(len));
    chk(mism == 0, "R5 data bytes", mis_act, mis_exp);
    chk(ordbad == 0 && n30 == 2, "R1 die order", n30 * 10 + ordbad, 20);
    chk(rowcap[0] == r1 && rowcap[1] == r2 && colbad == 0, "R1 address bytes",
        int'(rowcap[1]), int'(r2));
    chk(r2bad == 0, "R2 ready/busy ordering", r2bad, 0);
    chk(polls0 >= 1 && polls1 >= 1 && badrd == 0, "R3 poll before data",
        polls0 * 100 + polls1 * 10 + badrd, 110);
    chk(n70 == 0, "R4 no 70h", n70, 0);
    chk(cont == 0, "R9 bus contention", cont, 0);
    chk(errn == 0, inject ? "R11 request while busy ignored" : "R6 no error", errn, 0);
    chk(!busy, "R5 idle after pass", busy, 0);
  endtask

  task automatic req_err(input [1:0] o1, input [1:0] o2, input int code, input string req);
    clear();
    start(o1, o2, 24'h000010, 24'h800020, 4);
    chk(err == 1'b1 && err_code == 2'(code), req, int'(err_code), code);
    repeat (6) @(negedge clk);
    chk(nwe == 0 && !busy, {req, " no bus activity"}, nwe, 0);
  endtask

  localparam logic [91:0] VEC [4] = '{
    {24'h000123, 24'h800456, 12'd5, 16'd40, 16'd60},
    {24'h012345, 24'h8ABCDE, 12'd1, 16'd30, 16'd30},
    {24'h00F0FF, 24'h80FF01, 12'd8, 16'd55, 16'd35},
    {24'h000777, 24'h800888, 12'd0, 16'd35, 16'd50}
  };

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe && !err,
        "R10 reset state", {busy, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 6'b011000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      logic [91:0] v;
      v = VEC[i];
      run_vec(v[91:68], v[67:44], v[43:32], v[31:16], v[15:0], 1'b0);
    end

    req_err(2'd0, 2'd1, 1, "R6 mixed ops");
    req_err(2'd2, 2'd0, 1, "R6 mixed ops reversed");
    req_err(2'd1, 2'd1, 2, "R7 cache read rejected");
    req_err(2'd2, 2'd2, 2, "R7 copyback rejected");
    req_err(2'd3, 2'd3, 2, "R7 reserved op rejected");

    clear();
    bdur[0] = 16'd3000; bdur[1] = 16'd3000; e_row[0] = 24'h000055; e_row[1] = 24'h800066;
    start(2'd0, 2'd0, 24'h000055, 24'h800066, 4);
    wait_end();
    chk(errn == 1 && lcode == 2'd3, "R8 timeout code", int'(lcode), 3);
    chk(polls0 == MAXP && polls1 == 0, "R8 poll limit", polls0, MAXP);
    chk(d1n == 0 && d2n == 0 && nbytes == 0 && !busy, "R8 abort", d1n + d2n + nbytes, 0);
    chk(n70 == 0, "R4 no 70h during timeout", n70, 0);

    run_vec(24'h000A0B, 24'h800C0D, 12'd3, 16'd45, 16'd40, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule